// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable stand-in for a small serial non-volatile memory of 64 words, each 16 bits wide. A host reaches it over three wires plus a select: a chip-select level, a serial clock, a serial data input and a data output that the block can release. Each transaction begins when chip select rises. The host then sends a start bit, a 2-bit operation code and a 6-bit address, most significant bit first. Depending on the code, the block returns a word, takes 16 more data bits, or acts at once.

Every programming operation is gated by an enable latch, and that latch is clear after reset. Erasing a word, erasing all words, writing a word and writing one pattern to every word each start a self-timed programming interval. A down-counter measured in system clocks models that interval. If the host drops chip select and raises it again while the interval is still running, the output pin reports busy and then ready. Chip select, serial clock and data are oversampled by a system clock that runs at least four times faster than the serial clock.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset every word reads as 16'hFFFF, the enable latch is clear and `ser_dout_en` is 0.
- R2: A frame is a 1 start bit, then a 2-bit operation code, then a 6-bit address, all MSB first and sampled on rising `ser_clk`. Zeros sent before the start bit are skipped.
- R3: Code 2'b10 (read) drives a single 0 bit after the last address bit. It then drives D15 down to D0, and each bit changes after a rising `ser_clk`.
- R4: Code 2'b01 (write) takes 16 data bits MSB first and stores them at the address.
- R5: Code 2'b11 (erase) sets the addressed word to 16'hFFFF. Code 2'b00 with address bits [5:4]=2'b10 sets every word to 16'hFFFF.
- R6: Code 2'b00 with address bits [5:4]=2'b01 takes 16 data bits and stores them into every word.
- R7: Code 2'b00 with address bits [5:4]=2'b11 sets the enable latch, and [5:4]=2'b00 clears it. While the latch is clear, any programming frame leaves memory unchanged and starts no busy interval.
- R8: A read returns stored data whether the enable latch is set or clear.
- R9: The busy interval lasts exactly PROG_CYCLES system clocks. It starts once the last data bit of a write or write-all is taken, or once the address of an erase or erase-all is taken.
- R10: When chip select is raised while the interval runs, the output is driven 0 and becomes 1 when the interval ends. When chip select is raised after the interval has ended, no status is driven.
- R11: `ser_dout_en` is 0 when chip select is low and when nothing is being returned. Extra serial clocks after a completed frame have no effect until chip select falls.
- R12: A frame that begins while the interval runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Chip select, active high; a rising level begins a frame |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data or ready/busy status to the host |
| ser_dout_en | output | 1 | Output enable for `ser_dout`; 0 means high impedance |

## Verification
The hardest case to reach is a ready/busy report. It needs chip select to drop and rise again inside the programming interval. A second frame must also arrive in that window and be refused. The stimulus paces the serial clock at a fixed number of system clocks, so it knows when the last data bit lands. It re-raises chip select a few clocks after that point. It samples the status once well before and once well after the PROG_CYCLES boundary, and starts an erase during the interval that a later read must show had no effect. The disabled-latch paths are then confirmed through reads and through the absence of any status.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int OP_W    = 2;
    localparam int HDR_W   = OP_W + ADDR_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam int SUB_W   = 2;

    localparam logic [DATA_W-1:0] ERASED_WORD = '1;

    typedef enum logic [OP_W-1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [SUB_W-1:0] {
        EX_LOCK   = 2'b00,
        EX_FILL   = 2'b01,
        EX_WIPE   = 2'b10,
        EX_UNLOCK = 2'b11
    } ext_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_HDR,
        S_DATA,
        S_READ,
        S_STATUS,
        S_DONE
    } fsm_e;

    typedef struct packed {
        logic              valid;
        logic              all;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } prog_req_t;

    function automatic op_e hdr_op(input logic [HDR_W-1:0] h);
        return op_e'(h[HDR_W-1 -: OP_W]);
    endfunction

    function automatic ext_e hdr_ext(input logic [HDR_W-1:0] h);
        return ext_e'(h[ADDR_W-1 -: SUB_W]);
    endfunction

endpackage

// File: rtl/nvm_front.sv
module nvm_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_raw,
    input  logic sk_raw,
    input  logic di_raw,
    output logic cs_lvl,
    output logic di_lvl,
    output logic sk_rise
);
    localparam int W = 3;

    logic [W-1:0] stage_q [STAGES];
    logic         sk_last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= {cs_raw, sk_raw, di_raw};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sk_last_q <= 1'b0;
        else     sk_last_q <= stage_q[STAGES-1][1];
    end

    assign cs_lvl  = stage_q[STAGES-1][2];
    assign di_lvl  = stage_q[STAGES-1][0];
    assign sk_rise = stage_q[STAGES-1][1] & ~sk_last_q;

endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  prog_req_t         req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                words_q[i] <= ERASED_WORD;
            else if (req.valid && (req.all || req.addr == ADDR_W'(i)))
                words_q[i] <= req.data;
        end
    end

    assign rd_word = words_q[rd_addr];

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (go)
            left_q <= TW'(PROG_CYCLES);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/nvm_cmd_fsm.sv
module nvm_cmd_fsm
    import nvm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_lvl,
    input  logic              di_lvl,
    input  logic              sk_rise,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output prog_req_t         req,
    output logic              wen,
    output logic              sdo,
    output logic              sdo_en
);
    fsm_e              state_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [DATA_W-1:0] dsh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sdo_q;
    logic              wen_q;
    prog_req_t         req_q;

    logic [HDR_W-1:0]  nxt_hdr;
    logic [DATA_W-1:0] nxt_dat;

    always_comb begin
        nxt_hdr = {hdr_q[HDR_W-2:0], di_lvl};
        nxt_dat = {dsh_q[DATA_W-2:0], di_lvl};
    end

    assign rd_addr = nxt_hdr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            hdr_q   <= '0;
            dsh_q   <= '0;
            cnt_q   <= '0;
            sdo_q   <= 1'b0;
            wen_q   <= 1'b0;
            req_q   <= '0;
        end else begin
            req_q.valid <= 1'b0;
            if (!cs_lvl) begin
                state_q <= S_IDLE;
            end else begin
                unique case (state_q)
                    S_IDLE: state_q <= busy ? S_STATUS : S_START;
                    S_START: begin
                        if (sk_rise && di_lvl) begin
                            state_q <= S_HDR;
                            cnt_q   <= '0;
                        end
                    end
                    S_HDR: begin
                        if (sk_rise) begin
                            hdr_q <= nxt_hdr;
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(HDR_W - 1)) begin
                                cnt_q   <= '0;
                                state_q <= S_DONE;
                                unique case (hdr_op(nxt_hdr))
                                    OP_READ: begin
                                        dsh_q   <= rd_word;
                                        sdo_q   <= 1'b0;
                                        state_q <= S_READ;
                                    end
                                    OP_WRITE: state_q <= S_DATA;
                                    OP_ERASE: begin
                                        req_q <= '{valid: wen_q, all: 1'b0,
                                                   addr: nxt_hdr[ADDR_W-1:0],
                                                   data: ERASED_WORD};
                                    end
                                    OP_EXT: begin
                                        unique case (hdr_ext(nxt_hdr))
                                            EX_UNLOCK: wen_q <= 1'b1;
                                            EX_LOCK:   wen_q <= 1'b0;
                                            EX_WIPE: begin
                                                req_q <= '{valid: wen_q, all: 1'b1,
                                                           addr: '0,
                                                           data: ERASED_WORD};
                                            end
                                            EX_FILL: state_q <= S_DATA;
                                        endcase
                                    end
                                endcase
                            end
                        end
                    end
                    S_DATA: begin
                        if (sk_rise) begin
                            dsh_q <= nxt_dat;
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(DATA_W - 1)) begin
                                req_q <= '{valid: wen_q,
                                           all: (hdr_op(hdr_q) == OP_EXT),
                                           addr: hdr_q[ADDR_W-1:0],
                                           data: nxt_dat};
                                state_q <= S_DONE;
                            end
                        end
                    end
                    S_READ: begin
                        if (sk_rise) begin
                            if (cnt_q == CNT_W'(DATA_W)) begin
                                state_q <= S_DONE;
                            end else begin
                                sdo_q <= dsh_q[DATA_W-1];
                                dsh_q <= {dsh_q[DATA_W-2:0], 1'b0};
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    S_STATUS: state_q <= S_STATUS;
                    S_DONE:   state_q <= S_DONE;
                    default:  state_q <= S_IDLE;
                endcase
            end
        end
    end

    assign req    = req_q;
    assign wen    = wen_q;
    assign sdo_en = (state_q == S_READ) || (state_q == S_STATUS);
    assign sdo    = (state_q == S_STATUS) ? ~busy : sdo_q;

endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
    import nvm_pkg::*;
#(
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_din,
    output logic ser_dout,
    output logic ser_dout_en
);
    logic              cs_lvl;
    logic              di_lvl;
    logic              sk_rise;
    logic              prog_busy;
    logic              prog_go;
    logic              wr_enabled;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;
    prog_req_t         prog_req;

    nvm_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst     (rst),
        .cs_raw  (chip_sel),
        .sk_raw  (ser_clk),
        .di_raw  (ser_din),
        .cs_lvl  (cs_lvl),
        .di_lvl  (di_lvl),
        .sk_rise (sk_rise)
    );

    nvm_cmd_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cs_lvl  (cs_lvl),
        .di_lvl  (di_lvl),
        .sk_rise (sk_rise),
        .busy    (prog_busy),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .req     (prog_req),
        .wen     (wr_enabled),
        .sdo     (ser_dout),
        .sdo_en  (ser_dout_en)
    );

    assign prog_go = prog_req.valid;

    nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .go   (prog_go),
        .busy (prog_busy)
    );

    nvm_store u_store (
        .clk     (clk),
        .rst     (rst),
        .req     (prog_req),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

endmodule

// File: rtl/nvm_checker.sv
module nvm_checker #(
    parameter int PROG_CYCLES = 2000
) (
    input logic clk,
    input logic rst,
    input logic chip_sel,
    input logic dout_en,
    input logic prog_go,
    input logic prog_busy,
    input logic wen
);
    logic [2:0] cs_low_run;
    int         busy_run;

    always_ff @(posedge clk) begin
        if (rst)                  cs_low_run <= '0;
        else if (chip_sel)        cs_low_run <= '0;
        else if (cs_low_run != 3'd7) cs_low_run <= cs_low_run + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            busy_run <= 0;
        else if (prog_busy) busy_run <= busy_run + 1;
        else                busy_run <= 0;
    end

    assert_hiz_deselected_R11: assert property (@(posedge clk) disable iff (rst)
        (cs_low_run >= 3'd4) |-> !dout_en);

    assert_go_starts_busy_R9: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> prog_busy);

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_busy) |-> (busy_run == PROG_CYCLES));

    assert_no_start_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
        prog_busy |-> !prog_go);

    assert_busy_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> $past(wen));

endmodule

bind serial_nvm_slave nvm_checker #(.PROG_CYCLES(PROG_CYCLES)) u_nvm_chk (
    .clk       (clk),
    .rst       (rst),
    .chip_sel  (chip_sel),
    .dout_en   (ser_dout_en),
    .prog_go   (prog_go),
    .prog_busy (prog_busy),
    .wen       (wr_enabled)
);

// File: tb/test_serial_nvm_slave.sv
module test_serial_nvm_slave;

    localparam int PROG = 2000;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, dout_en;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [16:0] exp_q [$];
    logic [16:0] act_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    serial_nvm_slave #(.PROG_CYCLES(PROG)) i_serial_nvm_slave (
        .clk(clk), .rst(rst), .chip_sel(cs), .ser_clk(sk), .ser_din(di),
        .ser_dout(dout), .ser_dout_en(dout_en)
    );

    task automatic check(input logic [16:0] act, input logic [16:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sk_cycle(input logic b, output logic s);
        @(negedge clk) di = b;
        repeat (HALF) @(negedge clk);
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        s  = dout_en ? dout : 1'bx;
        sk = 1'b0;
    endtask

    task automatic cs_up();
        @(negedge clk) cs = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) cs = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [5:0] addr,
                         input bit has_data, input logic [15:0] data);
        logic s;
        cs_up();
        sk_cycle(1'b1, s);
        for (int i = 1; i >= 0; i--) sk_cycle(op[i], s);
        for (int i = 5; i >= 0; i--) sk_cycle(addr[i], s);
        if (has_data)
            for (int i = 15; i >= 0; i--) sk_cycle(data[i], s);
        cs_down();
    endtask

    task automatic settle();
        repeat (PROG + 100) @(negedge clk);
    endtask

    // Driver: pushes the expected {dummy, word} and gathers what DO returns.
    task automatic do_read(input logic [5:0] addr, input logic [15:0] exp,
                           input string tag, input bit lead_zeros);
        logic        s;
        logic [16:0] got;
        exp_q.push_back({1'b0, exp});
        tag_q.push_back(tag);
        cs_up();
        if (lead_zeros) begin
            sk_cycle(1'b0, s);
            sk_cycle(1'b0, s);
        end
        sk_cycle(1'b1, s);
        sk_cycle(1'b1, s);
        sk_cycle(1'b0, s);
        for (int i = 5; i >= 0; i--) sk_cycle(addr[i], s);
        got[16] = s;
        for (int i = 15; i >= 0; i--) begin
            sk_cycle(1'b0, s);
            got[i] = s;
        end
        act_q.push_back(got);
        cs_down();
    endtask

    // Monitor: pairs produced read results with expected items.
    initial begin
        forever begin
            wait (act_q.size() > 0);
            check(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic s;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        check({16'b0, dout_en}, 17'd0, "R1 dout_en after reset");
        cs_up();
        check({16'b0, dout_en}, 17'd0, "R11 no drive on idle select");
        cs_down();
        do_read(6'd0, 16'hFFFF, "R1 erased at reset", 1'b0);

        // R7: write while latch clear is dropped, no busy started
        frame(2'b01, 6'd5, 1, 16'h1234);
        cs_up();
        check({16'b0, dout_en}, 17'd0, "R7 no status when locked");
        cs_down();
        do_read(6'd5, 16'hFFFF, "R7 locked write ignored", 1'b0);

        // R7 unlock, R4 write, R2 leading zeros, R3 read format
        frame(2'b00, 6'b110000, 0, 16'h0);
        frame(2'b01, 6'd5, 1, 16'hA55A);
        settle();
        do_read(6'd5, 16'hA55A, "R4 write word 5", 1'b0);
        do_read(6'd5, 16'hA55A, "R2 leading zeros skipped", 1'b1);
        do_read(6'd4, 16'hFFFF, "R3 neighbour untouched", 1'b0);

        // R10/R9 status polling
        frame(2'b01, 6'd63, 1, 16'h0001);
        cs_up();
        check({15'b0, dout_en, dout}, 17'b10, "R10 busy shown");
        repeat (PROG - 100) @(negedge clk);
        check({15'b0, dout_en, dout}, 17'b10, "R9 still busy near end");
        repeat (200) @(negedge clk);
        check({15'b0, dout_en, dout}, 17'b11, "R10 ready shown");
        cs_down();
        cs_up();
        check({16'b0, dout_en}, 17'd0, "R10 no status after end");
        cs_down();
        do_read(6'd63, 16'h0001, "R4 write top word", 1'b0);

        // R12: erase during busy is refused
        frame(2'b01, 6'd10, 1, 16'h1111);
        frame(2'b11, 6'd10, 0, 16'h0);
        settle();
        do_read(6'd10, 16'h1111, "R12 erase while busy ignored", 1'b0);

        // R5 single erase
        frame(2'b11, 6'd5, 0, 16'h0);
        settle();
        do_read(6'd5, 16'hFFFF, "R5 erase word 5", 1'b0);
        do_read(6'd10, 16'h1111, "R5 erase other kept", 1'b0);

        // R6 write-all
        frame(2'b00, 6'b010000, 1, 16'h3C3C);
        settle();
        do_read(6'd0, 16'h3C3C, "R6 fill word 0", 1'b0);
        do_read(6'd33, 16'h3C3C, "R6 fill word 33", 1'b0);
        do_read(6'd63, 16'h3C3C, "R6 fill word 63", 1'b0);

        // R5 erase-all
        frame(2'b00, 6'b100000, 0, 16'h0);
        settle();
        do_read(6'd7, 16'hFFFF, "R5 wipe word 7", 1'b0);
        do_read(6'd63, 16'hFFFF, "R5 wipe word 63", 1'b0);

        // R11 extra clocks after a read release DO
        cs_up();
        sk_cycle(1'b1, s); sk_cycle(1'b1, s); sk_cycle(1'b0, s);
        for (int i = 0; i < 6; i++) sk_cycle(1'b0, s);
        for (int i = 0; i < 16; i++) sk_cycle(1'b0, s);
        for (int i = 0; i < 3; i++) sk_cycle(1'b1, s);
        check({16'b0, dout_en}, 17'd0, "R11 extra clocks after read");
        cs_down();

        // R7 lock, R8 reads still work
        frame(2'b01, 6'd2, 1, 16'h0F0F);
        settle();
        frame(2'b00, 6'b000000, 0, 16'h0);
        frame(2'b11, 6'd2, 0, 16'h0);
        cs_up();
        check({16'b0, dout_en}, 17'd0, "R7 locked erase no busy");
        cs_down();
        frame(2'b00, 6'b010000, 1, 16'h0000);
        frame(2'b00, 6'b100000, 0, 16'h0);
        settle();
        do_read(6'd2, 16'h0F0F, "R8 read while locked", 1'b0);
        do_read(6'd3, 16'hFFFF, "R7 locked fill ignored", 1'b0);

        wait (act_q.size() == 0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule